// File: doc/BRIEF.md
# Multi-Format Stereo Serial Transmitter

This block turns a pair of parallel audio samples (one for the left channel, one for the right) into a serial bit stream. It generates a frame sync and a bit clock from the system clock. Each frame holds 64 bit-clock periods, with 32 for each channel. The left half of the frame is always sent first. A two-bit code picks one of four framings: I2S, left-justified, right-justified with 20 data bits, and right-justified with 16 data bits. The same framing applies to every output.

There are two data outputs, and both carry the same stream. The first output is active whenever the block is enabled. The second output also needs its own enable. The bit clock is only driven onto its pin when the clock-output enable is set. Frame sync and data run whether or not the clock is driven, so a receiver that makes its own clock can still follow the stream. The block takes new samples and a new format code only at the start of a frame. Data changes only on a falling edge of the bit clock. Any data output that is disabled is held low.

Top module: `stereo_serial_tx`

## Requirements
- R1: The format code `fmtSel` selects the framing. 2'b00 is I2S, 2'b01 is left-justified, 2'b10 is right-justified with the upper 20 sample bits, and 2'b11 is right-justified with the upper 16 sample bits.
- R2: The internal bit clock has a period of 2*HALF_DIV system clocks. It is low after reset and while disabled. A frame lasts exactly 64 bit-clock periods. The left channel takes slots 0 to 31 and the right channel takes slots 32 to 63. Slot 0 starts at the first falling edge after enable, which comes 2*HALF_DIV cycles after enable is seen.
- R3: In I2S framing, `fsyncOut` is low for the left half and high for the right half. The sample MSB is sent in slot 1 of each half, followed by the other bits MSB first. All remaining slots are 0.
- R4: In left-justified framing, `fsyncOut` is high for the left half and low for the right half. The MSB is sent in slot 0 of each half, followed by the other bits MSB first. All remaining slots are 0.
- R5: In the right-justified framings, `fsyncOut` behaves as in R4. The LSB of the 20-bit or 16-bit word falls on slot 31 of each half. All slots before the word are 0.
- R6: Data and frame sync change only on a falling edge of the bit clock. Samples and the format code are captured at the falling edge that starts slot 0. Changes to them within a frame take effect in the next frame.
- R7: While `enable` is 0, the outputs `sdo1`, `sdo2`, `fsyncOut` and `bclkOut` are all 0 from the next clock edge on. Re-enabling starts a fresh frame as described in R2.
- R8: `sdo2` carries the same bit as `sdo1` while `secondEn` is 1, and is 0 while `secondEn` is 0.
- R9: `bclkOut` is the internal bit clock while `clkOutEn` is 1, and is 0 otherwise. `clkOutEn` has no effect on the data or the frame sync.
- R10: Both data outputs always use the framing selected for the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Master enable for the serializer |
| secondEn | input | 1 | Enable for the second data output |
| clkOutEn | input | 1 | Drives the bit clock onto `bclkOut` |
| fmtSel | input | 2 | Framing select (see R1) |
| leftSample | input | SAMPLE_W | Left channel sample |
| rightSample | input | SAMPLE_W | Right channel sample |
| bclkOut | output | 1 | Gated bit clock |
| fsyncOut | output | 1 | Frame sync (channel select) |
| sdo1 | output | 1 | First serial data output |
| sdo2 | output | 1 | Second serial data output |

## Verification
`sdo1` and `fsyncOut` are registered on the same system-clock edge where the internal bit clock falls. That is also the edge where `bclkOut` drops, when it is enabled. `sdo2` and `bclkOut` follow `secondEn` and `clkOutEn` in the same cycle. Clearing `enable` silences the outputs one edge later. New samples and a new format code appear only in the next frame, starting 2*HALF_DIV cycles after a frame boundary. The bench drives its inputs 2 ns after each rising edge and compares at the falling edge against a cycle model of these latencies. It also decodes whole half-frames from the pins and measures the frame period.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJ20 = 2'b10,
    FMT_RJ16 = 2'b11
  } fmt_e;

  localparam int SLOT_W    = 6;
  localparam int HALF_BITS = 32;
  localparam int RJ_LONG   = 20;
  localparam int RJ_SHORT  = 16;

  // control-to-datapath strobes
  typedef struct packed {
    logic              clear;
    logic              fall;
    logic              frameStart;
    logic [SLOT_W-1:0] nextSlot;
  } strobe_t;
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output strobe_t           stb,
  output logic              bclkInt,
  output logic [SLOT_W-1:0] slot
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic divEnd;

  assign divEnd = (divCnt == DIV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt  <= '0;
      bclkInt <= 1'b0;
      slot    <= '1;
    end else if (!en) begin
      divCnt  <= '0;
      bclkInt <= 1'b0;
      slot    <= '1;
    end else if (divEnd) begin
      divCnt  <= '0;
      bclkInt <= ~bclkInt;
      if (bclkInt) slot <= slot + 1'b1;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    stb.clear      = !en;
    stb.fall       = en && divEnd && bclkInt;
    stb.nextSlot   = slot + 1'b1;
    stb.frameStart = stb.fall && (stb.nextSlot == '0);
  end

  // R2: the bit clock toggles only at the end of a divider count
  p_bclk_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(bclkInt)) |-> ($past(divCnt) == DIV_LAST));
endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [SAMPLE_W-1:0] leftIn,
  input  logic [SAMPLE_W-1:0] rightIn,
  input  logic [1:0]          fmtSel,
  output logic                sdo,
  output logic                fsync,
  output fmt_e                fmtQ
);
  logic [SAMPLE_W-1:0] leftQ, rightQ, curL, curR, word;
  fmt_e curFmt;
  logic [4:0] pos;
  logic isRight, nextBit, nextFs;

  function automatic logic pickBit(fmt_e f, logic [4:0] p, logic [SAMPLE_W-1:0] s);
    int idx;
    logic [SAMPLE_W-1:0] sh;
    case (f)
      FMT_I2S:  idx = (int'(p) >= 1) ? SAMPLE_W - int'(p) : -1;
      FMT_LJ:   idx = SAMPLE_W - 1 - int'(p);
      FMT_RJ20: idx = (int'(p) >= HALF_BITS - RJ_LONG)
                      ? SAMPLE_W - RJ_LONG + HALF_BITS - 1 - int'(p) : -1;
      default:  idx = (int'(p) >= HALF_BITS - RJ_SHORT)
                      ? SAMPLE_W - RJ_SHORT + HALF_BITS - 1 - int'(p) : -1;
    endcase
    if (idx < 0 || idx >= SAMPLE_W) return 1'b0;
    sh = s >> idx;
    return sh[0];
  endfunction

  always_comb begin
    curL    = stb.frameStart ? leftIn  : leftQ;
    curR    = stb.frameStart ? rightIn : rightQ;
    curFmt  = stb.frameStart ? fmt_e'(fmtSel) : fmtQ;
    pos     = stb.nextSlot[4:0];
    isRight = stb.nextSlot[SLOT_W-1];
    word    = isRight ? curR : curL;
    nextBit = pickBit(curFmt, pos, word);
    nextFs  = (curFmt == FMT_I2S) ? isRight : !isRight;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo <= 1'b0; fsync <= 1'b0; fmtQ <= FMT_I2S;
      leftQ <= '0; rightQ <= '0;
    end else if (stb.clear) begin
      sdo <= 1'b0; fsync <= 1'b0; fmtQ <= FMT_I2S;
      leftQ <= '0; rightQ <= '0;
    end else if (stb.fall) begin
      sdo   <= nextBit;
      fsync <= nextFs;
      if (stb.frameStart) begin
        leftQ  <= leftIn;
        rightQ <= rightIn;
        fmtQ   <= fmt_e'(fmtSel);
      end
    end
  end

  // R6: data only moves on a bit-clock falling edge
  p_data_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clear && !$past(stb.clear) && !$stable(sdo)) |-> $past(stb.fall));
  // R6: format is held for the whole frame
  p_fmt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.clear && !$past(stb.clear) && !$stable(fmtQ)) |-> $past(stb.frameStart));
endmodule

// File: rtl/stereo_serial_tx.sv
module stereo_serial_tx
  import sertx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                secondEn,
  input  logic                clkOutEn,
  input  logic [1:0]          fmtSel,
  input  logic [SAMPLE_W-1:0] leftSample,
  input  logic [SAMPLE_W-1:0] rightSample,
  output logic                bclkOut,
  output logic                fsyncOut,
  output logic                sdo1,
  output logic                sdo2
);
  strobe_t stb;
  logic bclkInt, sdoInt, fsInt;
  logic [SLOT_W-1:0] slot;
  fmt_e fmtQ;

  sertx_ctrl #(.HALF_DIV(HALF_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(enable),
    .stb(stb), .bclkInt(bclkInt), .slot(slot)
  );

  sertx_dp #(.SAMPLE_W(SAMPLE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .leftIn(leftSample), .rightIn(rightSample), .fmtSel(fmtSel),
    .sdo(sdoInt), .fsync(fsInt), .fmtQ(fmtQ)
  );

  assign bclkOut  = bclkInt & clkOutEn;
  assign fsyncOut = fsInt;
  assign sdo1     = sdoInt;
  assign sdo2     = sdoInt & secondEn;

  // R7: disabled block goes quiet at the next edge
  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sdo1 && !fsyncOut && !bclkOut));
  // R3: frame sync only moves at a half-frame boundary
  p_fsync_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && !$stable(fsyncOut)) |-> (slot[4:0] == 5'd0));
  // R5: leading slots of a 16-bit right-justified half are zero
  p_rj16_lead_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && fmtQ == FMT_RJ16 && slot[4:0] < 5'd16) |-> !sdoInt);
endmodule

// File: tb/tb_stereo_serial_tx.sv
`timescale 1ns/1ps
module tb_stereo_serial_tx;
  localparam int SW = 24;
  localparam int HD = 2;

  logic clk = 0, rst_n = 0, enable = 0, secondEn = 0, clkOutEn = 0;
  logic [1:0] fmtSel = 0;
  logic [SW-1:0] leftSample = 0, rightSample = 0;
  logic bclkOut, fsyncOut, sdo1, sdo2;

  int nChk = 0, nBad = 0;
  bit done = 0, modelOn = 0;

  always #10 clk = ~clk;

  stereo_serial_tx #(.SAMPLE_W(SW), .HALF_DIV(HD)) dut (.*);

  // reference model built from the requirements
  int mDiv; logic mB, mSdo, mFs; int mSlot;
  logic [1:0] mFmt; logic [SW-1:0] mL, mR;

  function automatic logic expBit(logic [1:0] f, int p, logic [SW-1:0] s);
    logic [31:0] w;
    case (f)
      2'b00: w = {1'b0, s, 7'b0};          // R3
      2'b01: w = {s, 8'b0};                // R4
      2'b10: w = {12'b0, s[SW-1:SW-20]};   // R5
      default: w = {16'b0, s[SW-1:SW-16]}; // R5
    endcase
    return w[31-p];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !enable) begin
      mDiv = 0; mB = 0; mSlot = 63; mSdo = 0; mFs = 0; mFmt = 0; mL = 0; mR = 0;
    end else if (mDiv == HD-1) begin
      mDiv = 0;
      if (mB) begin
        mB = 0;
        mSlot = (mSlot + 1) % 64;
        if (mSlot == 0) begin mL = leftSample; mR = rightSample; mFmt = fmtSel; end
        mSdo = expBit(mFmt, mSlot % 32, (mSlot >= 32) ? mR : mL);
        mFs  = (mFmt == 2'b00) ? (mSlot >= 32) : (mSlot < 32);
      end else mB = 1;
    end else mDiv++;
  end

  task automatic check(string tag, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s t=%0t actual=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  task automatic checkWord(string tag, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string dataTag(logic [1:0] f);
    return (f == 2'b00) ? "R3 R6 R10 sdo1" : (f == 2'b01) ? "R4 R6 R10 sdo1" : "R5 R6 R10 sdo1";
  endfunction

  always @(negedge clk) if (modelOn && rst_n) begin
    check(dataTag(mFmt), sdo1, mSdo);
    check("R8 sdo2", sdo2, mSdo & secondEn);
    check("R9 bclkOut", bclkOut, mB & clkOutEn);
    check("R2 fsync", fsyncOut, mFs);
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  // wait at negedges for the next bit-clock fall
  task automatic nextFall();
    logic prev;
    prev = bclkOut;
    forever begin
      @(negedge clk);
      if (prev && !bclkOut) break;
      prev = bclkOut;
    end
  endtask

  // capture a left half-frame: lvl is the sync level meaning "left"
  task automatic grabLeft(logic lvl, output logic [31:0] w);
    logic prev;
    @(negedge clk); prev = fsyncOut;
    forever begin
      @(negedge clk);
      if (prev != lvl && fsyncOut == lvl) break;
      prev = fsyncOut;
    end
    w = {31'b0, sdo1};
    for (int i = 1; i < 32; i++) begin nextFall(); w = {w[30:0], sdo1}; end
  endtask

  task automatic directed(logic [1:0] f, logic [31:0] exp, string tag);
    logic [31:0] w;
    fmtSel = f;
    tick(2 * 64 * 2 * HD);
    grabLeft(f != 2'b00, w);
    checkWord(tag, w, exp);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [SW-1:0] L;
    int t0, t1;
    void'($urandom(32'd20240611));
    tick(3);
    // R7: reset state
    check("R7 reset sdo1", sdo1, 0);
    check("R7 reset fsync", fsyncOut, 0);
    check("R7 reset bclk", bclkOut, 0);
    rst_n = 1; tick(2);
    enable = 1; clkOutEn = 1; secondEn = 1; modelOn = 1;
    L = 24'hB3_C5_A9;
    leftSample = L; rightSample = 24'h5A_0F_F0;
    // R1 format codes decoded from the pins
    directed(2'b00, {1'b0, L, 7'b0}, "R1 R3 I2S left word");
    directed(2'b01, {L, 8'b0}, "R1 R4 LJ left word");
    directed(2'b10, {12'b0, L[23:4]}, "R1 R5 RJ20 left word");
    directed(2'b11, {16'b0, L[23:8]}, "R1 R5 RJ16 left word");
    // R2: frame length from sync rises
    fmtSel = 2'b01; tick(2 * 256);
    @(posedge fsyncOut); t0 = $time;
    @(posedge fsyncOut); t1 = $time;
    nChk++;
    if ((t1 - t0) != 64 * 2 * HD * 20) begin
      nBad++;
      $display("FAIL R2 frame period actual=%0d expected=%0d", t1 - t0, 64 * 2 * HD * 20);
    end
    // R9: clock gate off, data continues
    clkOutEn = 0; tick(300);
    clkOutEn = 1;
    // R7: disable mid-frame, then restart
    tick(77); enable = 0; tick(1);
    @(negedge clk);
    check("R7 disabled sdo1", sdo1, 0);
    check("R7 disabled fsync", fsyncOut, 0);
    tick(10); enable = 1;
    // random phase mixed with the cycle model
    for (int c = 0; c < 60000; c++) begin
      tick(1);
      if ($urandom_range(0, 9) == 0) leftSample = SW'($urandom);
      if ($urandom_range(0, 9) == 0) rightSample = SW'($urandom);
      if ($urandom_range(0, 299) == 0) fmtSel = 2'($urandom);
      if ($urandom_range(0, 199) == 0) secondEn = ~secondEn;
      if ($urandom_range(0, 199) == 0) clkOutEn = ~clkOutEn;
      if ($urandom_range(0, 2999) == 0) enable = ~enable;
      else if (!enable && $urandom_range(0, 19) == 0) enable = 1;
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule